// File: doc/BRIEF.md
# VGA Text Display Controller

This block drives a monochrome 640x480 display at 60 Hz from a character buffer. The screen is a grid of 80 columns by 30 rows of 8x16-pixel cells, 2400 characters in all. The processor sees the buffer as 600 packed 32-bit words at a memory-mapped base, starting at 0xFFFF_0100. The block receives the byte offset from that base, so word n covers offsets 4n to 4n+3. Each word carries four character codes.

For every pixel the controller works out which cell the beam is in and reads the word that holds that cell's code. It sends the code and the pixel line inside the cell to an external glyph store. One clock later it receives that line's 8-pixel bitmap and picks out the pixel. A buffer read followed by a glyph lookup takes two clocks, so the sync and blanking signals are delayed by two clocks to stay aligned with the pixel data. Glyph storage, colour and scrolling are handled elsewhere.

Top module: `vga_text_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block holds hsync_n=1, vsync_n=1, video=0 and cpu_rdata=0. The scan position restarts at column 0 of line 0 on the first edge after release.
- R2: A line is 800 clocks long, with positions 0 to 639 visible. hsync_n is low for line positions 656 to 751 and high elsewhere. It appears two clocks after the scan position it belongs to.
- R3: A frame is 525 lines long, with lines 0 to 479 visible. vsync_n is low on lines 490 and 491 and high on all other lines. It has the same two-clock delay as hsync_n.
- R4: When cpu_we is high at a clock edge, cpu_wdata is stored in word cpu_waddr[11:2] if that word is below 600. Address bits [1:0] are ignored.
- R5: A write to word 600 or above changes no stored word. A read of word 600 or above returns 0.
- R6: cpu_rdata returns the word at cpu_raddr[11:2] one clock after the address is presented.
- R7: The character at text row r and column c has index i = r*80 + c. Its code is byte i mod 4 of word i/4, where byte k occupies bits [8k+7:8k].
- R8: One clock after a scan position (x, y), glyph_code carries that position's character code and glyph_row carries y mod 16. glyph_bits is taken as the bitmap of that request one clock later.
- R9: video equals bit 7 - (x mod 8) of glyph_bits two clocks after scan position (x, y) when x < 640 and y < 480, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Word write strobe |
| cpu_waddr | input | 12 | Write byte offset from the buffer base |
| cpu_wdata | input | 32 | Write word, four character codes |
| cpu_raddr | input | 12 | Read byte offset from the buffer base |
| cpu_rdata | output | 32 | Read word, one clock after the address |
| glyph_code | output | 8 | Character code sent to the glyph store |
| glyph_row | output | 4 | Pixel line inside the cell |
| glyph_bits | input | 8 | Bitmap line returned one clock after the request |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| video | output | 1 | Monochrome pixel |

## Verification
The buffer is filled with seeded random words. The fill also includes a few directed words: all zeros, all ones, and mixed bytes at the first and last words. This separates byte-lane order from word order and from row-major indexing. Writes use nonzero low address bits, and writes at and beyond word 600 must leave the contents unchanged. Every pixel, sync level and glyph request is then compared over many lines of the full-size screen and over two complete frames of a short-frame instance. These comparisons show whether the bit-order, porch or sync edges, or the line and frame wrap are misplaced by even one clock.

// File: rtl/vga_text_pkg.sv
// Shared types for the text display controller.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package vga_text_pkg;

    // Per-pixel control flags that travel alongside the pixel data.
    typedef struct packed {
        logic vis;   // scan position lies inside the visible area
        logic hs;    // horizontal sync pulse is active
        logic vs;    // vertical sync pulse is active
    } scan_ctl_t;

    localparam scan_ctl_t SCAN_IDLE = '{vis: 1'b0, hs: 1'b0, vs: 1'b0};

endpackage

// File: rtl/vga_scan_timing.sv
// Raster scan counters and raw sync/visible decode.
// Assumes: one clock per pixel; the totals fit in HW and VW bits.
module vga_scan_timing
    import vga_text_pkg::*;
#(
    parameter int H_VIS  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_VIS  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter int HW     = 10,
    parameter int VW     = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt,
    output scan_ctl_t     ctl
);
    localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] HS_BEG = HW'(H_VIS + H_FP);
    localparam logic [HW-1:0] HS_END = HW'(H_VIS + H_FP + H_SYNC);
    localparam logic [VW-1:0] VS_BEG = VW'(V_VIS + V_FP);
    localparam logic [VW-1:0] VS_END = VW'(V_VIS + V_FP + V_SYNC);

    // Advance the pixel counter and, at the end of each line, the line counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (h_cnt == H_LAST) begin
            h_cnt <= '0;
            v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

    // Decode the visible window and both sync pulses from the counters.
    always_comb begin
        ctl.vis = (h_cnt < HW'(H_VIS)) && (v_cnt < VW'(V_VIS));
        ctl.hs  = (h_cnt >= HS_BEG) && (h_cnt < HS_END);
        ctl.vs  = (v_cnt >= VS_BEG) && (v_cnt < VS_END);
    end

    // The pixel counter restarts after the last clock of a line.
    assert_line_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt == H_LAST) |=> (h_cnt == '0));

    // The line counter restarts after the last line of a frame.
    assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt == H_LAST && v_cnt == V_LAST) |=> (v_cnt == '0));

    // Within a line the line counter holds still.
    assert_line_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt != H_LAST) |=> $stable(v_cnt));

endmodule

// File: rtl/vga_text_buffer.sv
// Character store: 32-bit words holding four codes each.
// One CPU write port, one CPU read port and one pixel-side read port.
// Assumes: byte addressing on the CPU side, low two bits ignored;
// out-of-range words are dropped on write and read as zero.
module vga_text_buffer #(
    parameter int WORDS = 600,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_waddr,
    input  logic [31:0]   cpu_wdata,
    input  logic [AW-1:0] cpu_raddr,
    output logic [31:0]   cpu_rdata,
    input  logic [AW-3:0] pix_word,
    output logic [31:0]   pix_data
);
    localparam int IW = AW - 2;
    localparam int MW = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [IW-1:0] WORDS_L = IW'(WORDS);

    logic [31:0]   mem [WORDS];
    logic [IW-1:0] w_word, r_word;
    logic          w_ok, r_ok, p_ok;
    logic          unused_low;

    assign w_word     = cpu_waddr[AW-1:2];
    assign r_word     = cpu_raddr[AW-1:2];
    assign w_ok       = (w_word < WORDS_L);
    assign r_ok       = (r_word < WORDS_L);
    assign p_ok       = (pix_word < WORDS_L);
    assign unused_low = ^{cpu_waddr[1:0], cpu_raddr[1:0]};

    // Store a CPU word when it addresses an existing entry.
    always_ff @(posedge clk) begin
        if (cpu_we && w_ok) begin
            mem[w_word[MW-1:0]] <= cpu_wdata;
        end
    end

    // Return the CPU read word one clock after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else begin
            cpu_rdata <= r_ok ? mem[r_word[MW-1:0]] : '0;
        end
    end

    // Fetch the word under the beam for the pixel pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_data <= '0;
        end else begin
            pix_data <= p_ok ? mem[pix_word[MW-1:0]] : '0;
        end
    end

    // A write into range lands in the addressed entry.
    assert_word_stored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && w_ok) |=> (mem[$past(w_word[MW-1:0])] == $past(cpu_wdata)));

    // A read outside the buffer returns zero.
    assert_oob_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_ok) |=> (cpu_rdata == 32'd0));

endmodule

// File: rtl/vga_pixel_pipe.sv
// Turns a scan position into a pixel: word fetch, byte pick, glyph request,
// bit pick. Sync and visible flags ride two stages to stay aligned.
// Assumes: CHAR_W and CHAR_H are powers of two; glyph bitmaps return one
// clock after the request, leftmost pixel in the top bit.
module vga_pixel_pipe
    import vga_text_pkg::*;
#(
    parameter int COLS   = 80,
    parameter int CHAR_W = 8,
    parameter int CHAR_H = 16,
    parameter int HW     = 10,
    parameter int VW     = 10,
    parameter int IW     = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [HW-1:0]             h_cnt,
    input  logic [VW-1:0]             v_cnt,
    input  scan_ctl_t                 ctl_in,
    output logic [IW-1:0]             pix_word,
    input  logic [31:0]               pix_data,
    output logic [7:0]                glyph_code,
    output logic [$clog2(CHAR_H)-1:0] glyph_row,
    input  logic [CHAR_W-1:0]         glyph_bits,
    output logic                      hsync_n,
    output logic                      vsync_n,
    output logic                      video
);
    localparam int CW_L = $clog2(CHAR_W);
    localparam int CH_L = $clog2(CHAR_H);
    localparam int XW   = IW + 2;

    logic [HW-CW_L-1:0] col;
    logic [VW-CH_L-1:0] row;
    logic [XW-1:0]      idx;
    logic [1:0]         sel1;
    logic [CH_L-1:0]    gy1;
    logic [CW_L-1:0]    px1, px2;
    scan_ctl_t          ctl1, ctl2;

    // Row-major character index of the cell under the beam.
    always_comb begin
        col      = h_cnt[HW-1:CW_L];
        row      = v_cnt[VW-1:CH_L];
        idx      = XW'(row) * XW'(COLS) + XW'(col);
        pix_word = idx[XW-1:2];
    end

    // Stage 1: hold byte lane, cell line, pixel column and flags during the word fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel1 <= '0;
            gy1  <= '0;
            px1  <= '0;
            ctl1 <= SCAN_IDLE;
        end else begin
            sel1 <= idx[1:0];
            gy1  <= v_cnt[CH_L-1:0];
            px1  <= h_cnt[CW_L-1:0];
            ctl1 <= ctl_in;
        end
    end

    // Pick the character byte out of the fetched word for the glyph request.
    always_comb begin
        glyph_code = pix_data[{sel1, 3'b000} +: 8];
        glyph_row  = gy1;
    end

    // Stage 2: hold pixel column and flags during the glyph lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px2  <= '0;
            ctl2 <= SCAN_IDLE;
        end else begin
            px2  <= px1;
            ctl2 <= ctl1;
        end
    end

    // Select the pixel bit (leftmost is the top bit) and drive syncs.
    always_comb begin
        video   = ctl2.vis & glyph_bits[~px2];
        hsync_n = ~ctl2.hs;
        vsync_n = ~ctl2.vs;
    end

    // Nothing lights outside the visible window, two clocks on.
    assert_blank_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctl_in.vis, 2)) |-> (!video));

    // Horizontal sync trails the scan decode by exactly two clocks.
    assert_hsync_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_n == !$past(ctl_in.hs, 2)));

    // Vertical sync trails the scan decode by exactly two clocks.
    assert_vsync_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_n == !$past(ctl_in.vs, 2)));

    // The glyph line request follows the scan line by one clock.
    assert_glyph_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (glyph_row == $past(v_cnt[CH_L-1:0])));

endmodule

// File: rtl/vga_text_ctrl.sv
// Top of the text display controller: scan timing, character buffer and
// pixel pipeline. Assumes a pixel clock for the chosen timing and an
// external glyph store with one clock of latency.
module vga_text_ctrl
    import vga_text_pkg::*;
#(
    parameter int COLS   = 80,
    parameter int ROWS   = 30,
    parameter int CHAR_W = 8,
    parameter int CHAR_H = 16,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter int CPU_AW = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_we,
    input  logic [CPU_AW-1:0]         cpu_waddr,
    input  logic [31:0]               cpu_wdata,
    input  logic [CPU_AW-1:0]         cpu_raddr,
    output logic [31:0]               cpu_rdata,
    output logic [7:0]                glyph_code,
    output logic [$clog2(CHAR_H)-1:0] glyph_row,
    input  logic [CHAR_W-1:0]         glyph_bits,
    output logic                      hsync_n,
    output logic                      vsync_n,
    output logic                      video
);
    localparam int H_VIS = COLS * CHAR_W;
    localparam int V_VIS = ROWS * CHAR_H;
    localparam int WORDS = (COLS * ROWS) / 4;
    localparam int HW    = $clog2(H_VIS + H_FP + H_SYNC + H_BP);
    localparam int VW    = $clog2(V_VIS + V_FP + V_SYNC + V_BP);
    localparam int IW    = CPU_AW - 2;

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    scan_ctl_t     ctl;
    logic [IW-1:0] pix_word;
    logic [31:0]   pix_data;

    vga_scan_timing #(
        .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .HW(HW), .VW(VW)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt), .ctl(ctl)
    );

    vga_text_buffer #(.WORDS(WORDS), .AW(CPU_AW)) u_buffer (
        .clk(clk), .rst_n(rst_n),
        .cpu_we(cpu_we), .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata),
        .cpu_raddr(cpu_raddr), .cpu_rdata(cpu_rdata),
        .pix_word(pix_word), .pix_data(pix_data)
    );

    vga_pixel_pipe #(
        .COLS(COLS), .CHAR_W(CHAR_W), .CHAR_H(CHAR_H),
        .HW(HW), .VW(VW), .IW(IW)
    ) u_pipe (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt), .ctl_in(ctl),
        .pix_word(pix_word), .pix_data(pix_data),
        .glyph_code(glyph_code), .glyph_row(glyph_row), .glyph_bits(glyph_bits),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .video(video)
    );

    // Reset holds all outputs at their idle levels on the following edge.
    assert_reset_idle_R1: assert property (@(posedge clk)
        (!rst_n) |=> (hsync_n && vsync_n && !video && cpu_rdata == 32'd0));

endmodule

// File: tb/tb_vga_text_ctrl.sv
// Bench: random and directed buffer contents, port checks, and a pixel-exact
// comparison on a full-size instance and on a short-frame instance.
module tb_vga_text_ctrl;
    localparam int WORDS = 600;
    localparam int SMALL_WORDS = 40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, cpu_we;
    logic [11:0] cpu_waddr, cpu_raddr;
    logic [31:0] cpu_wdata;
    logic [31:0] rd_a, rd_b;
    logic [7:0]  gc_a, gc_b, gb_a, gb_b;
    logic [3:0]  gr_a, gr_b;
    logic        hs_a, vs_a, vid_a, hs_b, vs_b, vid_b;

    int   errors = 0;
    int   checks = 0;
    int   n;
    bit   chk_on = 1'b0;
    bit   done = 1'b0;
    logic [31:0] shadow [WORDS];

    vga_text_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_waddr(cpu_waddr),
        .cpu_wdata(cpu_wdata), .cpu_raddr(cpu_raddr), .cpu_rdata(rd_a),
        .glyph_code(gc_a), .glyph_row(gr_a), .glyph_bits(gb_a),
        .hsync_n(hs_a), .vsync_n(vs_a), .video(vid_a)
    );

    // Short frame: 2 text rows, 39 lines per frame, same line timing.
    vga_text_ctrl #(.ROWS(2), .V_FP(2), .V_SYNC(2), .V_BP(3)) dut_frame (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_waddr(cpu_waddr),
        .cpu_wdata(cpu_wdata), .cpu_raddr(cpu_raddr), .cpu_rdata(rd_b),
        .glyph_code(gc_b), .glyph_row(gr_b), .glyph_bits(gb_b),
        .hsync_n(hs_b), .vsync_n(vs_b), .video(vid_b)
    );

    function automatic logic [7:0] gfn(input logic [7:0] c, input logic [3:0] r);
        return (c * 8'd13) ^ {r, ~r};
    endfunction

    // External glyph store model: one clock of latency.
    always @(posedge clk) begin
        gb_a <= gfn(gc_a, gr_a);
        gb_b <= gfn(gc_b, gr_b);
    end

    // Clock edges since reset release.
    always @(posedge clk) begin
        if (!rst_n) n <= 0;
        else        n <= n + 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] char_at(input int idx);
        logic [31:0] w;
        w = shadow[idx / 4];
        return w[8 * (idx % 4) +: 8];
    endfunction

    // Compare one instance against the scan model for the current edge count.
    task automatic scan_check(input string tag, input int vt, input int vvis,
                              input int vfp, input int vsy,
                              input logic hs, input logic vs, input logic vid,
                              input logic [7:0] gc, input logic [3:0] gr);
        int p, h, v, idx;
        bit vis;
        logic [7:0] g;
        logic [2:0] bi;
        if (n >= 1) begin
            p = n - 1;
            h = p % 800;
            v = (p / 800) % vt;
            chk("R8", {tag, " glyph_row"}, 32'(gr), 32'(v % 16));
            if (h < 640 && v < vvis) begin
                idx = (v / 16) * 80 + h / 8;
                chk("R7", {tag, " glyph_code"}, 32'(gc), 32'(char_at(idx)));
            end
        end
        if (n >= 2) begin
            p = n - 2;
            h = p % 800;
            v = (p / 800) % vt;
            vis = (h < 640) && (v < vvis);
            chk("R2", {tag, " hsync_n"}, 32'(hs), (h >= 656 && h < 752) ? 32'd0 : 32'd1);
            chk("R3", {tag, " vsync_n"}, 32'(vs),
                (v >= vvis + vfp && v < vvis + vfp + vsy) ? 32'd0 : 32'd1);
            if (vis) begin
                idx = (v / 16) * 80 + h / 8;
                g   = gfn(char_at(idx), 4'(v % 16));
                bi  = 3'(7 - (h % 8));
                chk("R9", {tag, " video"}, 32'(vid), 32'(g[bi]));
            end else begin
                chk("R9", {tag, " video blank"}, 32'(vid), 32'd0);
            end
        end else begin
            chk("R1", {tag, " hsync_n early"}, 32'(hs), 32'd1);
            chk("R1", {tag, " video early"}, 32'(vid), 32'd0);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            scan_check("main", 525, 480, 10, 2, hs_a, vs_a, vid_a, gc_a, gr_a);
            scan_check("short", 39, 32, 2, 2, hs_b, vs_b, vid_b, gc_b, gr_b);
        end
    end

    task automatic cpu_write(input int word, input int lowbits, input logic [31:0] d);
        cpu_waddr = 12'(word * 4 + lowbits);
        cpu_wdata = d;
        cpu_we    = 1'b1;
        @(negedge clk);
        cpu_we    = 1'b0;
    endtask

    task automatic reset_checks(input string when);
        chk("R1", {when, " hsync_n"}, 32'(hs_a), 32'd1);
        chk("R1", {when, " vsync_n"}, 32'(vs_a), 32'd1);
        chk("R1", {when, " video"}, 32'(vid_a), 32'd0);
        chk("R1", {when, " cpu_rdata"}, rd_a, 32'd0);
        chk("R1", {when, " short hsync_n"}, 32'(hs_b), 32'd1);
        chk("R1", {when, " short video"}, 32'(vid_b), 32'd0);
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd24681357));
        rst_n = 1'b0; cpu_we = 1'b0;
        cpu_waddr = '0; cpu_raddr = '0; cpu_wdata = '0;
        repeat (4) @(negedge clk);
        reset_checks("first reset");
        rst_n = 1'b1;

        // Fill with random words plus directed patterns; low address bits vary (R4).
        for (int w = 0; w < WORDS; w++) begin
            d = $urandom;
            if (w == 0)   d = 32'h0000_0000;
            if (w == 1)   d = 32'hFFFF_FFFF;
            if (w == 2)   d = 32'h8001_7F10;
            if (w == 599) d = 32'h7E81_0018;
            shadow[w] = d;
            cpu_write(w, w % 4, d);
        end

        // Out-of-range writes must not land anywhere (R5).
        cpu_write(600, 0, 32'hDEAD_BEEF);
        cpu_write(1023, 3, 32'hCAFE_F00D);
        cpu_write(SMALL_WORDS, 0, 32'h1234_5678);
        shadow[SMALL_WORDS] = 32'h1234_5678;

        // Read back everything, one clock latency (R6, R4, R5).
        for (int w = 0; w < WORDS; w++) begin
            cpu_raddr = 12'(w * 4 + (3 - w % 4));
            @(negedge clk);
            chk("R6", $sformatf("read word %0d", w), rd_a, shadow[w]);
            if (w < SMALL_WORDS)
                chk("R4", $sformatf("short read word %0d", w), rd_b, shadow[w]);
            else
                chk("R5", $sformatf("short oob read %0d", w), rd_b, 32'd0);
        end
        cpu_raddr = 12'd2400;
        @(negedge clk);
        chk("R5", "read word 600", rd_a, 32'd0);
        cpu_raddr = 12'd4095;
        @(negedge clk);
        chk("R5", "read word 1023", rd_a, 32'd0);
        cpu_raddr = 12'(88 * 4);
        @(negedge clk);
        chk("R5", "alias word 88 untouched", rd_a, shadow[88]);

        // Restart the scan and compare every pixel.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        reset_checks("second reset");
        rst_n  = 1'b1;
        chk_on = 1'b1;
        repeat (2 * 39 * 800 + 40) @(negedge clk);
        chk_on = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(150000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule